// File: doc/BRIEF.md
# Routed I/O Interrupt Controller

This block collects 32 external interrupt lines and delivers each one to a grid of 4 cores by 4 CPU interrupt pins. Every line has its own sense: level or edge, active-high or active-low, rising or falling. A line is delivered only while it is both asserted in status and enabled. Software-facing state sits behind a small memory-mapped register port. A bank of route bytes, one byte per line, says which core/pin pairs each line reaches. A control block holds status, the enable mask, polarity and trigger mode.

Raw lines pass through a two-flop synchronizer before detection. Edge events are held in sticky latches until software writes 1 to clear them. Level lines simply follow the polarity-adjusted input. The enable mask is changed through separate set and clear registers, so no read-modify-write is needed to change one line. Every route byte can select several cores and pins, which fans a line out to each selected pair. The 16 request outputs are registered.

Top module: `irq_router_top`

## Requirements
- R1: After reset every request output is 0. The enable mask reads 0, polarity (0x30) reads 0xFFFFFFFF, trigger mode (0x38) reads 0, and every route word reads 0.
- R2: A full-word write to 0x28 sets each enable bit written as 1. A full-word write to 0x2C clears each enable bit written as 1. Bits written as 0 leave their enable unchanged. The mask reads back at 0x24.
- R3: A line whose mode bit is 0 is level-sensitive. Its status bit (0x20) equals the input when its polarity bit is 1 and the inverted input when its polarity bit is 0. Writing to status has no effect on such a line.
- R4: A line whose mode bit is 1 is edge-sensitive. A rising edge (polarity 1) or a falling edge (polarity 0) sets its status bit, and the bit stays set after the input returns. Writing 1 to that status bit clears it, and an edge of the opposite direction does not set it.
- R5: A line is pending only when its status bit and its enable bit are both 1. A disabled line drives no request output, yet its raw status stays readable.
- R6: The route byte of line i sits at byte offset i. Bit n of its low nibble selects core n, and bit m of its high nibble selects pin m. Output irq_req[4*c+p] is the OR of every pending line whose route selects core c and pin p.
- R7: A route byte with several core and pin bits set drives every selected core/pin pair at once.
- R8: In a write to offset 0x00..0x1C, each asserted byte enable b writes the route byte of line offset+b, and other route bytes keep their values. A read returns the four route bytes of the word, with the lowest line in bits 7:0.
- R9: Writes to control registers take effect only when all four byte enables are set. Partial writes are ignored.
- R10: Reads of 0x28, 0x2C, 0x34, 0x3C and of misaligned addresses return 0. Writes to 0x24, 0x34, 0x3C or misaligned addresses change nothing.
- R11: For a level line, an input change driven before rising edge k appears on the request output after edge k+2. For an edge line it appears after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Raw interrupt lines, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the access, word aligned |
| bus_be | input | 4 | Byte enables of a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 16 | Request wires, index 4*core+pin |

## Verification
The bench writes a status clear to a level line and checks that the line stays asserted; a design that latched every line would drop it. It drives edges of the wrong direction on an edge line, and returns the input to idle after a real edge; a design that ignored polarity or did not latch would raise or lose the request. Single-lane route writes are checked to leave neighbouring bytes intact, and partial control writes are checked to change nothing; a design that ignored byte enables would corrupt the route table. Exact edge counts are measured for level and edge latency, so an extra or missing pipeline stage shows up.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int LINES   = 32;
  localparam int CORES   = 4;
  localparam int PINS    = 4;
  localparam int AW      = 6;
  localparam int DW      = 32;
  localparam int NREQ    = CORES * PINS;

  // Word indices (bus_addr[5:2]) of the control block
  localparam logic [3:0] W_STATUS = 4'd8;
  localparam logic [3:0] W_ENVIEW = 4'd9;
  localparam logic [3:0] W_ENSET  = 4'd10;
  localparam logic [3:0] W_ENCLR  = 4'd11;
  localparam logic [3:0] W_POLAR  = 4'd12;
  localparam logic [3:0] W_MODE   = 4'd14;

  // Does a route byte steer its line to core c, pin p?
  function automatic logic route_sel(input logic [7:0] rb, input int c, input int p);
    return rb[c] & rb[4 + p];
  endfunction

  // Edge of the requested direction between previous and current sample
  function automatic logic edge_seen(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Polarity-adjusted level
  function automatic logic level_active(input logic cur, input logic pol);
    return pol ? cur : ~cur;
  endfunction
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] s_cur,
  output logic [W-1:0] s_prev
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign s_cur  = sync_q;
  assign s_prev = hist_q;
endmodule

// File: rtl/irq_trigger_unit.sv
module irq_trigger_unit
  import irq_router_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_cur,
  input  logic [W-1:0] s_prev,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status,
  output logic [W-1:0] edge_hit
);
  logic [W-1:0] latch_q;
  logic [W-1:0] lvl;

  for (genvar i = 0; i < W; i++) begin : g_line
    assign edge_hit[i] = edge_seen(s_cur[i], s_prev[i], pol[i]);
    assign lvl[i]      = level_active(s_cur[i], pol[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= ((latch_q & ~clr) | edge_hit) & mode;
  end

  assign status = (mode & latch_q) | (~mode & lvl);
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_router_pkg::*;
#(
  parameter int N  = 32,
  parameter int NC = 4,
  parameter int NP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pending,
  input  logic [N*8-1:0]   routes,
  output logic [NC*NP-1:0] req
);
  logic [NC*NP-1:0] req_d;

  for (genvar c = 0; c < NC; c++) begin : g_core
    for (genvar p = 0; p < NP; p++) begin : g_pin
      always_comb begin
        req_d[c*NP+p] = 1'b0;
        for (int i = 0; i < N; i++)
          req_d[c*NP+p] = req_d[c*NP+p] | (pending[i] & route_sel(routes[i*8 +: 8], c, p));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= '0;
    else        req <= req_d;
  end
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [NREQ-1:0] irq_req
);
  // Decode
  logic       aligned, in_ctl, in_route, wr_ctl;
  logic [3:0] word;
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign word     = bus_addr[5:2];
  assign in_ctl   = aligned & bus_addr[5];
  assign in_route = aligned & ~bus_addr[5];
  assign wr_ctl   = bus_wr & in_ctl & (bus_be == 4'hF);

  // Named internal events (also observed by the checker)
  logic [LINES-1:0] en_set_w, en_clr_w, stat_clr_w;
  logic [LINES-1:0] pending_w, status_w, edge_hit_w;
  logic [LINES-1:0] s_cur_w, s_prev_w;
  assign en_set_w   = (wr_ctl && word == W_ENSET)  ? bus_wdata : '0;
  assign en_clr_w   = (wr_ctl && word == W_ENCLR)  ? bus_wdata : '0;
  assign stat_clr_w = (wr_ctl && word == W_STATUS) ? bus_wdata : '0;

  // Control registers
  logic [LINES-1:0] en_q, pol_q, mode_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      mode_q <= '0;
    end else begin
      en_q <= (en_q | en_set_w) & ~en_clr_w;
      if (wr_ctl && word == W_POLAR) pol_q  <= bus_wdata;
      if (wr_ctl && word == W_MODE)  mode_q <= bus_wdata;
    end
  end

  // Route table, one byte per line
  logic [7:0]       rt_q [LINES];
  logic [LINES*8-1:0] rt_flat;
  for (genvar i = 0; i < LINES; i++) begin : g_route
    logic we;
    assign we = bus_wr & in_route & (bus_addr[4:2] == 3'(i / 4)) & bus_be[i % 4];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rt_q[i] <= '0;
      else if (we) rt_q[i] <= bus_wdata[(i % 4)*8 +: 8];
    end
    assign rt_flat[i*8 +: 8] = rt_q[i];
  end

  // Datapath
  irq_sync_bank #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .s_cur(s_cur_w), .s_prev(s_prev_w)
  );

  irq_trigger_unit #(.W(LINES)) u_trig (
    .clk(clk), .rst_n(rst_n), .s_cur(s_cur_w), .s_prev(s_prev_w),
    .mode(mode_q), .pol(pol_q), .clr(stat_clr_w),
    .status(status_w), .edge_hit(edge_hit_w)
  );

  assign pending_w = status_w & en_q;

  irq_route_matrix #(.N(LINES), .NC(CORES), .NP(PINS)) u_matrix (
    .clk(clk), .rst_n(rst_n), .pending(pending_w), .routes(rt_flat), .req(irq_req)
  );

  // Read mux
  logic [2:0] rw;
  assign rw = bus_addr[4:2];
  always_comb begin
    bus_rdata = '0;
    if (in_route) begin
      bus_rdata = {rt_q[{rw, 2'd3}], rt_q[{rw, 2'd2}], rt_q[{rw, 2'd1}], rt_q[{rw, 2'd0}]};
    end else if (in_ctl) begin
      case (word)
        W_STATUS: bus_rdata = status_w;
        W_ENVIEW: bus_rdata = en_q;
        W_POLAR:  bus_rdata = pol_q;
        W_MODE:   bus_rdata = mode_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int LINES = 32,
  parameter int NREQ  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] en_q,
  input logic [LINES-1:0] en_set,
  input logic [LINES-1:0] en_clr,
  input logic [LINES-1:0] status,
  input logic [LINES-1:0] trig,
  input logic [LINES-1:0] stat_clr,
  input logic [LINES-1:0] pending,
  input logic [NREQ-1:0]  irq_req
);
  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set) |=> (($past(en_set) & ~en_q) == '0)); // R2
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> (($past(en_clr) & en_q) == '0)); // R2
  AST_ENABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_set == '0) && (en_clr == '0)) |=> $stable(en_q)); // R2
  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trig) == trig) |-> (($past(status & trig) & ~$past(stat_clr) & ~status) == '0)); // R4
  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> $past(|pending)); // R5
endmodule

bind irq_router_top irq_router_chk #(.LINES(32), .NREQ(16)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_set(en_set_w), .en_clr(en_clr_w),
  .status(status_w), .trig(mode_q), .stat_clr(stat_clr_w), .pending(pending_w),
  .irq_req(irq_req)
);

// File: tb/irq_router_top_tb.sv
`timescale 1ns/1ps
module irq_router_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_router_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    idle(1);
    check("R1 req", 32'(irq_req), 32'h0);
    rd(6'h24, d); check("R1 enable", d, 32'h0);
    rd(6'h30, d); check("R1 polarity", d, 32'hFFFF_FFFF);
    rd(6'h38, d); check("R1 mode", d, 32'h0);
    rd(6'h00, d); check("R1 route0", d, 32'h0);
    rd(6'h1C, d); check("R1 route7", d, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(6'h28, 32'hA5A5_0000, 4'hF);
    rd(6'h24, d); check("R2 set", d, 32'hA5A5_0000);
    wr(6'h28, 32'h0000_00F0, 4'hF);
    rd(6'h24, d); check("R2 set keeps", d, 32'hA5A5_00F0);
    wr(6'h2C, 32'h0500_0010, 4'hF);
    rd(6'h24, d); check("R2 clear", d, 32'hA0A5_00E0);
    wr(6'h2C, 32'hFFFF_FFFF, 4'hF);
    rd(6'h24, d); check("R2 clear all", d, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(6'h00, 32'h4200_0000, 4'b1000);  // line 3 -> core1 pin2
    wr(6'h28, 32'h0000_0008, 4'hF);
    irq_in[3] = 1'b1; idle(4);
    check("R6 level route", 32'(irq_req), 32'h0040);
    rd(6'h20, d); check("R3 status high", 32'(d[3]), 32'h1);
    wr(6'h20, 32'h0000_0008, 4'hF); idle(2);
    rd(6'h20, d); check("R3 status write ignored", 32'(d[3]), 32'h1);
    check("R3 req kept", 32'(irq_req), 32'h0040);
    wr(6'h30, 32'hFFFF_FFF7, 4'hF); idle(4);
    check("R3 active-low idle", 32'(irq_req), 32'h0);
    irq_in[3] = 1'b0; idle(4);
    check("R3 active-low asserted", 32'(irq_req), 32'h0040);
    wr(6'h2C, 32'h0000_0008, 4'hF); idle(3);
    check("R5 disabled quiet", 32'(irq_req), 32'h0);
    rd(6'h20, d); check("R5 raw visible", 32'(d[3]), 32'h1);
    wr(6'h30, 32'hFFFF_FFFF, 4'hF);
    wr(6'h00, 32'h0, 4'hF); idle(3);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(6'h08, 32'h0014_0000, 4'b0100);  // line 10 -> core2 pin0
    wr(6'h38, 32'h0000_0400, 4'hF);
    wr(6'h28, 32'h0000_0400, 4'hF);
    irq_in[10] = 1'b1; idle(5);
    check("R4 rising latched", 32'(irq_req), 32'h0100);
    irq_in[10] = 1'b0; idle(5);
    check("R4 held", 32'(irq_req), 32'h0100);
    rd(6'h20, d); check("R4 status held", 32'(d[10]), 32'h1);
    wr(6'h20, 32'h0000_0400, 4'hF); idle(3);
    check("R4 cleared", 32'(irq_req), 32'h0);
    rd(6'h20, d); check("R4 status cleared", 32'(d[10]), 32'h0);
    wr(6'h30, 32'hFFFF_FBFF, 4'hF);
    irq_in[10] = 1'b1; idle(5);
    check("R4 rise ignored when falling", 32'(irq_req), 32'h0);
    irq_in[10] = 1'b0; idle(5);
    check("R4 falling latched", 32'(irq_req), 32'h0100);
    wr(6'h20, 32'h0000_0400, 4'hF);
    wr(6'h30, 32'hFFFF_FFFF, 4'hF);
    wr(6'h38, 32'h0, 4'hF);
    wr(6'h2C, 32'hFFFF_FFFF, 4'hF);
    wr(6'h08, 32'h0, 4'hF); idle(3);
    check("R4 restored", 32'(irq_req), 32'h0);
  endtask

  task automatic t_fanout;
    wr(6'h14, 32'h0000_11FF, 4'b0011);  // line 20 -> all, line 21 -> core0 pin0
    wr(6'h28, 32'h0030_0000, 4'hF);
    irq_in[21] = 1'b1; idle(4);
    check("R6 single pair", 32'(irq_req), 32'h0001);
    irq_in[20] = 1'b1; idle(4);
    check("R7 fan-out all", 32'(irq_req), 32'hFFFF);
    irq_in[21] = 1'b0; idle(4);
    check("R7 fan-out alone", 32'(irq_req), 32'hFFFF);
    irq_in[20] = 1'b0; idle(4);
    check("R6 all idle", 32'(irq_req), 32'h0);
    wr(6'h2C, 32'hFFFF_FFFF, 4'hF);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    rd(6'h14, d); check("R8 read word", d, 32'h0000_11FF);
    wr(6'h14, 32'hAABB_CCDD, 4'b0100);
    rd(6'h14, d); check("R8 single lane", d, 32'h00BB_11FF);
    rd(6'h10, d); check("R8 neighbour word", d, 32'h0);
    wr(6'h14, 32'h0, 4'hF);
    rd(6'h14, d); check("R8 cleared", d, 32'h0);
  endtask

  task automatic t_partial;
    logic [31:0] d;
    wr(6'h28, 32'hFFFF_FFFF, 4'b0111);
    rd(6'h24, d); check("R9 partial enable", d, 32'h0);
    wr(6'h38, 32'hFFFF_FFFF, 4'b0001);
    rd(6'h38, d); check("R9 partial mode", d, 32'h0);
    wr(6'h30, 32'h0, 4'b1110);
    rd(6'h30, d); check("R9 partial polarity", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(6'h24, 32'hFFFF_FFFF, 4'hF);
    wr(6'h34, 32'hFFFF_FFFF, 4'hF);
    wr(6'h3C, 32'hFFFF_FFFF, 4'hF);
    wr(6'h29, 32'hFFFF_FFFF, 4'hF);
    wr(6'h01, 32'hFFFF_FFFF, 4'hF);
    rd(6'h24, d); check("R10 enview read-only", d, 32'h0);
    rd(6'h00, d); check("R10 misaligned route write", d, 32'h0);
    rd(6'h34, d); check("R10 read 0x34", d, 32'h0);
    rd(6'h3C, d); check("R10 read 0x3C", d, 32'h0);
    rd(6'h28, d); check("R10 read 0x28", d, 32'h0);
    rd(6'h2C, d); check("R10 read 0x2C", d, 32'h0);
    rd(6'h31, d); check("R10 misaligned read", d, 32'h0);
  endtask

  task automatic t_latency;
    wr(6'h00, 32'h0000_0011, 4'b0001);  // line 0 -> core0 pin0
    wr(6'h28, 32'h0000_0001, 4'hF);
    irq_in[0] = 1'b1;              // before edge k
    @(negedge clk); @(negedge clk);  // after edges k, k+1
    check("R11 level not yet", 32'(irq_req), 32'h0);
    @(negedge clk);                  // after edge k+2
    check("R11 level arrives", 32'(irq_req), 32'h0001);
    irq_in[0] = 1'b0; idle(4);
    wr(6'h38, 32'h0000_0001, 4'hF); idle(2);
    irq_in[0] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R11 edge not yet", 32'(irq_req), 32'h0);
    @(negedge clk);                  // after edge k+3
    check("R11 edge arrives", 32'(irq_req), 32'h0001);
    irq_in[0] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_level();
    t_edge();
    t_fanout();
    t_bytes();
    t_partial();
    t_unmapped();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule